// File: doc/BRIEF.md
# Scan Shift Toggle Meter

This block estimates the switching activity that a single scan test causes in a chain of flip-flops. It takes three chain-wide vectors: the pattern that will be loaded by shifting, the state the chain holds just before the capture clock, and the response that capture produces. It then reports three counts. The first is the shift-in toggle cost. The second is the shift-out toggle cost. The third is the number of cells that change value at capture.

Shift costs are weighted by position. A value change between two neighbouring bits travels through every cell it passes while the chain shifts, so it is counted once for each cell it crosses. A plain count of differing bits would not capture this.

The work is sequential and handles one bit position per clock. A start pulse samples the vectors and a budget limit. After the chain has been walked, a single-cycle done pulse presents the three counts, their total, and an over-budget flag. The flag tells a test controller whether the pattern exceeds the allowed activity.

Top module: `scan_toggle_meter`

## Requirements
- R1: After reset, busy_o, done_o and over_o are 0, and all four counts read 0.
- R2: Bit index 0 of each vector is the cell nearest scan-in. For position p from 1 to CHAIN_LEN-1, if load bits p-1 and p differ, shin_cnt_o includes CHAIN_LEN-p for that position.
- R3: For position p from 1 to CHAIN_LEN-1, if response bits p-1 and p differ, shout_cnt_o includes p for that position.
- R4: cap_cnt_o equals the number of bit indices where the pre-capture vector and the response vector differ.
- R5: When done_o is high, total_o equals shin_cnt_o + shout_cnt_o + cap_cnt_o. In that same cycle, over_o is 1 exactly when the total is strictly greater than the limit sampled at start.
- R6: A start while idle raises busy_o in the next cycle. done_o is high for exactly one cycle, and that cycle follows the CHAIN_LEN-th rising edge after the edge that sampled start. busy_o is low while done_o is high.
- R7: Vectors and limit are sampled only at an accepted start. A start pulse, or a change on any vector or the limit, while busy has no effect on the results that run reports.
- R8: Between a done pulse and the next accepted start, all counts and over_o hold their values whatever the inputs do.
- R9: An alternating pattern gives the worst shift cost CHAIN_LEN*(CHAIN_LEN-1)/2 per direction. The counters represent that value, and the full total, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a measurement (accepted when idle) |
| load_vec_i | input | CHAIN_LEN | Pattern to be shifted in, bit 0 nearest scan-in |
| resp_vec_i | input | CHAIN_LEN | Captured response to be shifted out |
| pre_vec_i | input | CHAIN_LEN | Chain state before capture |
| limit_i | input | CW | Activity budget |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| shin_cnt_o | output | CW | Weighted shift-in toggles |
| shout_cnt_o | output | CW | Weighted shift-out toggles |
| cap_cnt_o | output | CW | Capture toggles |
| total_o | output | CW | Sum of the three counts |
| over_o | output | 1 | Total exceeds the budget |

## Verification
The bench builds the block with CHAIN_LEN = 4, which gives a 5-bit counter width. At that size every one of the 16 load patterns can be walked. The all-alternating worst case reaches the counter's upper range, and the short run makes exact cycle-latency checks cheap. Budget limits are placed one below the total and exactly at it, so both sides of the comparison are exercised.

// File: rtl/stm_pkg.sv
package stm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } stm_state_e;
endpackage

// File: rtl/stm_step_calc.sv
module stm_step_calc #(
    parameter int unsigned CHAIN_LEN = 8,
    parameter int unsigned PW        = 3,
    parameter int unsigned CW        = 6
) (
    input  logic [PW-1:0]        pos_i,
    input  logic [CHAIN_LEN-1:0] ld_i,
    input  logic [CHAIN_LEN-1:0] rs_i,
    input  logic [CHAIN_LEN-1:0] pr_i,
    output logic [CW-1:0]        shin_inc_o,
    output logic [CW-1:0]        shout_inc_o,
    output logic [CW-1:0]        cap_inc_o
);
    logic [PW-1:0] pos_m1;
    logic          first_pos;
    logic          ld_edge;
    logic          rs_edge;
    logic          cap_diff;

    always_comb begin
        pos_m1    = pos_i - 1'b1;
        first_pos = (pos_i == '0);
        ld_edge   = !first_pos && (ld_i[pos_i] != ld_i[pos_m1]);
        rs_edge   = !first_pos && (rs_i[pos_i] != rs_i[pos_m1]);
        cap_diff  = (pr_i[pos_i] != rs_i[pos_i]);

        shin_inc_o  = ld_edge  ? (CW'(CHAIN_LEN) - CW'(pos_i)) : '0;
        shout_inc_o = rs_edge  ? CW'(pos_i) : '0;
        cap_inc_o   = cap_diff ? CW'(1) : '0;
    end
endmodule

// File: rtl/stm_budget.sv
module stm_budget #(
    parameter int unsigned CW = 6
) (
    input  logic [CW-1:0] shin_i,
    input  logic [CW-1:0] shout_i,
    input  logic [CW-1:0] cap_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] sum_o,
    output logic          over_o
);
    always_comb begin
        sum_o  = shin_i + shout_i + cap_i;
        over_o = (sum_o > limit_i);
    end
endmodule

// File: rtl/scan_toggle_meter.sv
module scan_toggle_meter #(
    parameter int unsigned CHAIN_LEN = 8,
    localparam int unsigned SHIFT_MAX = CHAIN_LEN * (CHAIN_LEN - 1) / 2,
    localparam int unsigned TOT_MAX   = 2 * SHIFT_MAX + CHAIN_LEN,
    localparam int unsigned CW        = $clog2(TOT_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CHAIN_LEN-1:0] load_vec_i,
    input  logic [CHAIN_LEN-1:0] resp_vec_i,
    input  logic [CHAIN_LEN-1:0] pre_vec_i,
    input  logic [CW-1:0]        limit_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [CW-1:0]        shin_cnt_o,
    output logic [CW-1:0]        shout_cnt_o,
    output logic [CW-1:0]        cap_cnt_o,
    output logic [CW-1:0]        total_o,
    output logic                 over_o
);
    import stm_pkg::*;

    localparam int unsigned PW = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(CHAIN_LEN - 1);

    typedef struct packed {
        stm_state_e           st;
        logic [PW-1:0]        pos;
        logic [CHAIN_LEN-1:0] ld;
        logic [CHAIN_LEN-1:0] rs;
        logic [CHAIN_LEN-1:0] pr;
        logic [CW-1:0]        lim;
        logic [CW-1:0]        shin;
        logic [CW-1:0]        shout;
        logic [CW-1:0]        cap;
        logic [CW-1:0]        tot;
        logic                 done;
        logic                 over;
    } regs_t;

    regs_t r_q, r_d;

    logic [CW-1:0] shin_inc, shout_inc, cap_inc;
    logic [CW-1:0] shin_nx, shout_nx, cap_nx;
    logic [CW-1:0] sum_w;
    logic          over_w;

    stm_step_calc #(
        .CHAIN_LEN (CHAIN_LEN),
        .PW        (PW),
        .CW        (CW)
    ) u_step (
        .pos_i       (r_q.pos),
        .ld_i        (r_q.ld),
        .rs_i        (r_q.rs),
        .pr_i        (r_q.pr),
        .shin_inc_o  (shin_inc),
        .shout_inc_o (shout_inc),
        .cap_inc_o   (cap_inc)
    );

    always_comb begin
        shin_nx  = r_q.shin  + shin_inc;
        shout_nx = r_q.shout + shout_inc;
        cap_nx   = r_q.cap   + cap_inc;
    end

    stm_budget #(
        .CW (CW)
    ) u_budget (
        .shin_i  (shin_nx),
        .shout_i (shout_nx),
        .cap_i   (cap_nx),
        .limit_i (r_q.lim),
        .sum_o   (sum_w),
        .over_o  (over_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_RUN;
                    r_d.pos   = '0;
                    r_d.ld    = load_vec_i;
                    r_d.rs    = resp_vec_i;
                    r_d.pr    = pre_vec_i;
                    r_d.lim   = limit_i;
                    r_d.shin  = '0;
                    r_d.shout = '0;
                    r_d.cap   = '0;
                    r_d.tot   = '0;
                    r_d.over  = 1'b0;
                end
            end
            ST_RUN: begin
                r_d.shin  = shin_nx;
                r_d.shout = shout_nx;
                r_d.cap   = cap_nx;
                if (r_q.pos == LAST_POS) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.tot  = sum_w;
                    r_d.over = over_w;
                end else begin
                    r_d.pos = r_q.pos + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st == ST_RUN);
    assign done_o      = r_q.done;
    assign shin_cnt_o  = r_q.shin;
    assign shout_cnt_o = r_q.shout;
    assign cap_cnt_o   = r_q.cap;
    assign total_o     = r_q.tot;
    assign over_o      = r_q.over;
endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
    parameter int unsigned CHAIN_LEN = 8,
    localparam int unsigned SHIFT_MAX = CHAIN_LEN * (CHAIN_LEN - 1) / 2,
    localparam int unsigned TOT_MAX   = 2 * SHIFT_MAX + CHAIN_LEN,
    localparam int unsigned CW        = $clog2(TOT_MAX + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic [CHAIN_LEN-1:0] load_vec_i,
    input logic [CHAIN_LEN-1:0] resp_vec_i,
    input logic [CHAIN_LEN-1:0] pre_vec_i,
    input logic [CW-1:0]        limit_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [CW-1:0]        shin_cnt_o,
    input logic [CW-1:0]        shout_cnt_o,
    input logic [CW-1:0]        cap_cnt_o,
    input logic [CW-1:0]        total_o,
    input logic                 over_o
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R6

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cap_cnt_o) <= int'(CHAIN_LEN)); // R4

    AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(shin_cnt_o) <= int'(SHIFT_MAX)) && (int'(shout_cnt_o) <= int'(SHIFT_MAX))); // R9

    AST_TOTAL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(total_o) == int'(shin_cnt_o) + int'(shout_cnt_o) + int'(cap_cnt_o))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(total_o) && $stable(cap_cnt_o) &&
                                   $stable(shin_cnt_o) && $stable(shout_cnt_o) && $stable(over_o))); // R8
endmodule

bind scan_toggle_meter stm_checker #(.CHAIN_LEN(CHAIN_LEN)) u_chk (.*);

// File: tb/sim_scan_toggle_meter.sv
`timescale 1ns/1ps
module sim_scan_toggle_meter;
    localparam int N  = 4;
    localparam int SM = N * (N - 1) / 2;
    localparam int CW = $clog2(2 * SM + N + 1);

    typedef struct {
        int shin;
        int shout;
        int cap;
        int tot;
        bit over;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  ld = '0, rs = '0, pr = '0;
    logic [CW-1:0] lim = '0;
    logic          busy, done, over;
    logic [CW-1:0] shin, shout, cap, tot;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    exp_t last_e;

    always #5 clk = ~clk;

    scan_toggle_meter #(.CHAIN_LEN(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .load_vec_i(ld), .resp_vec_i(rs), .pre_vec_i(pr), .limit_i(lim),
        .busy_o(busy), .done_o(done), .shin_cnt_o(shin), .shout_cnt_o(shout),
        .cap_cnt_o(cap), .total_o(tot), .over_o(over)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [N-1:0] l, input logic [N-1:0] r,
                                   input logic [N-1:0] p, input int limv);
        exp_t e;
        e.shin = 0; e.shout = 0; e.cap = 0;
        for (int i = 0; i < N; i++) begin
            if (p[i] != r[i]) e.cap++;
            if (i > 0) begin
                if (l[i] != l[i-1]) e.shin += N - i;
                if (r[i] != r[i-1]) e.shout += i;
            end
        end
        e.tot  = e.shin + e.shout + e.cap;
        e.over = (e.tot > limv);
        return e;
    endfunction

    // monitor: compares each done pulse against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check("R6 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R2 shin", int'(shin), e.shin);
                check("R3 shout", int'(shout), e.shout);
                check("R4 cap", int'(cap), e.cap);
                check("R5 total", int'(tot), e.tot);
                check("R5 over", int'(over), int'(e.over));
                check("R6 not busy at done", int'(busy), 0);
            end
        end
    end

    // driver: called at a negedge; disturb exercises R7
    task automatic run_vec(input logic [N-1:0] l, input logic [N-1:0] r,
                           input logic [N-1:0] p, input int limv, input bit disturb);
        int lat;
        last_e = model(l, r, p, limv);
        sb_q.push_back(last_e);
        ld = l; rs = r; pr = p; lim = CW'(limv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 busy after start", int'(busy), 1);
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 2) begin
                start = 1'b1; ld = ~l; rs = ~r; pr = ~p; lim = '0;
            end else if (disturb && lat == 3) begin
                start = 1'b0;
            end
        end
        check("R6 latency", lat, N + 1);
        start = 1'b0;
        @(negedge clk);
        check("R6 done single cycle", int'(done), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 over", int'(over), 0);
        check("R1 counts", int'(shin) + int'(shout) + int'(cap) + int'(tot), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // capture example: 1011 before, 0101 captured -> 3 capture toggles (R4)
        run_vec(4'b0000, 4'b0101, 4'b1011, 20, 1'b0);
        // worst case alternating, both directions at SM (R9)
        run_vec(4'b0101, 4'b1010, 4'b0101, 0, 1'b0);
        check("R9 worst shin", int'(shin), SM);
        check("R9 worst shout", int'(shout), SM);
        // single transition near each end (R2, R3)
        run_vec(4'b0001, 4'b0001, 4'b0000, 5, 1'b0);
        run_vec(4'b0111, 4'b0111, 4'b1111, 5, 1'b0);
        // budget boundary: limit = total -1 and limit = total (R5)
        begin
            exp_t e;
            e = model(4'b0110, 4'b0011, 4'b1100, 0);
            run_vec(4'b0110, 4'b0011, 4'b1100, e.tot - 1, 1'b0);
            check("R5 over at total-1", int'(over), 1);
            run_vec(4'b0110, 4'b0011, 4'b1100, e.tot, 1'b0);
            check("R5 not over at total", int'(over), 0);
        end
        // start and input changes while busy ignored (R7)
        run_vec(4'b1001, 4'b0110, 4'b0011, 7, 1'b1);
        // hold after done with wiggled inputs (R8)
        ld = 4'b1111; rs = 4'b0000; pr = 4'b1010; lim = '1;
        repeat (4) @(negedge clk);
        check("R8 hold shin", int'(shin), last_e.shin);
        check("R8 hold shout", int'(shout), last_e.shout);
        check("R8 hold cap", int'(cap), last_e.cap);
        check("R8 hold total", int'(tot), last_e.tot);
        check("R8 hold over", int'(over), int'(last_e.over));
        // sweep every load pattern (R2, R3, R4)
        for (int k = 0; k < 16; k++) begin
            run_vec(N'(k), N'(k * 5 + 3), N'(~k), k, 1'b0);
        end
        repeat (2) @(negedge clk);
        check("R6 scoreboard drained", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule